// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit half of a small Ethernet MAC as a host processor sees it across a memory-mapped bus. It holds two frame buffers, slot 0 and slot 1. Each slot has its own length register and its own status register. The host fills a slot with 32-bit writes, writes the frame length, then sets the busy bit in that slot's status register. The controller then streams the frame out, one byte per valid/ready handshake, with a marker on the final byte. When the final byte is accepted it drops busy and records a completion event.

A slot can also be launched in address-load mode. In that mode the first six bytes of the slot are copied into the station address output, and nothing is streamed. A level interrupt reports pending completions, gated per slot and by one global enable. The preamble, the frame check sequence and the PHY signalling belong to a later stage.

Top module: `ptx_tx_ctrl`

## Requirements
- R1: The byte address bit 11 selects the slot. Within a slot, offset 0x7F4 holds the frame length in bits [15:0] and reads back as written, and offset 0x7FC is the status register. Offset 0x7F8 of slot 0 holds the global interrupt enable in bit 31. Any other offset, including 0x7F8 of slot 1, reads as zero.
- R2: Stream byte k of a slot comes from buffer word k/4, lane k%4, which is bits [8*(k%4)+7 : 8*(k%4)], so byte 0 is the least significant byte. The last-byte marker is high only on the final byte.
- R3: Writing status bit 0 as 1 to an idle slot launches it. Bit 0 then reads 1 until the final byte is accepted, and 0 afterwards. A write to a busy slot does not relaunch it and does not change bits 0 and 1.
- R4: While the valid output is high and ready is low, valid, the data byte and the last marker hold their values.
- R5: When both slots are busy, frames leave in the order in which their busy bits were set. A slot launched while the other slot is sending waits for that frame to end.
- R6: A length above 1514 sends exactly 1514 bytes. A length of 0 sends no byte, and busy still clears and a completion is still recorded.
- R7: Writing status bits 0 and 1 together loads the station address output, with byte 0 in bits [47:40] through byte 5 in bits [7:0]. No byte is streamed, and both bits read 0 afterwards. Bit 1 written without bit 0 is ignored and reads 0.
- R8: Status bit 31 stores whatever the host writes and reads back unchanged. Hardware never alters it.
- R9: The interrupt output is high exactly while the global enable is set and at least one slot has both its status bit 3 set and a pending completion. A completion, frame or address load, sets that slot's pending event. Any host write to that slot's status register clears it.
- R10: After reset every register reads zero, and the valid, interrupt and station address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for host_addr, combinational |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| mac_addr | output | 48 | Loaded station address |
| irq | output | 1 | Transmit-complete interrupt, level |

## Verification
A fault in the launch-order record shows up at once as frames leaving out of order, or as a frame that is repeated or dropped. This is seen at the first byte of the affected frame. A wrong byte index or lane shows up as a data mismatch on the very byte involved, and a wrong end index shows up as a misplaced last marker. A stuck or missed pending event shows up on the interrupt pin one cycle after the final byte is accepted, or one cycle after the host's clearing write. A busy bit that clears early or late shows up in the next status read.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    localparam int HOST_AW    = 12;
    localparam int SLOT_OFS_W = HOST_AW - 1;
    localparam int BUS_W      = 32;
    localparam int NUM_SLOTS  = 2;

    localparam logic [SLOT_OFS_W-1:0] OFS_LEN  = 11'h7F4;
    localparam logic [SLOT_OFS_W-1:0] OFS_GIE  = 11'h7F8;
    localparam logic [SLOT_OFS_W-1:0] OFS_STAT = 11'h7FC;

    localparam int ST_BUSY = 0;
    localparam int ST_PROG = 1;
    localparam int ST_IE   = 3;
    localparam int ST_SW   = 31;
    localparam int GIE_BIT = 31;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEND,
        S_PROG_LO,
        S_PROG_HI
    } strm_e;
endpackage

// File: rtl/ptx_frame_ram.sv
module ptx_frame_ram #(
    parameter int WORD_AW = 9,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [WORD_AW:0]   waddr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [WORD_AW:0]   raddr_i,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int DEPTH = 2 << WORD_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ptx_slot.sv
module ptx_slot
    import ptx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat_i,
    input  logic              wr_len_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              done_i,
    output logic              prog_o,
    output logic              ie_o,
    output logic              pend_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [BUS_W-1:0]  stat_o,
    output logic              launch_o
);
    typedef struct packed {
        logic             busy;
        logic             prog;
        logic             ie;
        logic             sw;
        logic             pend;
        logic [LEN_W-1:0] len;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  launch;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        slot_d = slot_q;
        launch = wr_stat_i && wdata_i[ST_BUSY] && !slot_q.busy;
        if (wr_len_i) begin
            slot_d.len = wdata_i[LEN_W-1:0];
        end
        if (wr_stat_i) begin
            slot_d.ie   = wdata_i[ST_IE];
            slot_d.sw   = wdata_i[ST_SW];
            slot_d.pend = 1'b0;
        end
        if (launch) begin
            slot_d.busy = 1'b1;
            slot_d.prog = wdata_i[ST_PROG];
        end
        if (done_i) begin
            slot_d.busy = 1'b0;
            slot_d.prog = 1'b0;
            slot_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_comb begin
        stat_o          = '0;
        stat_o[ST_BUSY] = slot_q.busy;
        stat_o[ST_PROG] = slot_q.prog;
        stat_o[ST_IE]   = slot_q.ie;
        stat_o[ST_SW]   = slot_q.sw;
    end

    assign prog_o   = slot_q.prog;
    assign ie_o     = slot_q.ie;
    assign pend_o   = slot_q.pend;
    assign len_o    = slot_q.len;
    assign launch_o = launch;

    assert_done_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> stat_o[ST_BUSY]);

    assert_launch_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> stat_o[ST_BUSY]);

    assert_sw_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_i |=> $stable(stat_o[ST_SW]));
endmodule

// File: rtl/ptx_streamer.sv
module ptx_streamer
    import ptx_pkg::*;
#(
    parameter int MAX_LEN = 1514,
    parameter int LEN_W   = 16,
    parameter int WORD_AW = 9,
    parameter int MAC_W   = 48
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SLOTS-1:0]           launch_i,
    input  logic [NUM_SLOTS-1:0]           prog_i,
    input  logic [NUM_SLOTS-1:0][LEN_W-1:0] len_i,
    output logic [WORD_AW:0]               rd_addr_o,
    input  logic [BUS_W-1:0]               rd_data_i,
    output logic                           tx_valid_o,
    output logic [7:0]                     tx_data_o,
    output logic                           tx_last_o,
    input  logic                           tx_ready_i,
    output logic [NUM_SLOTS-1:0]           done_o,
    output logic [MAC_W-1:0]               mac_o
);
    typedef struct packed {
        strm_e            st;
        logic             slot;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] last;
        logic [1:0]       ord;
        logic [1:0]       cnt;
        logic [BUS_W-1:0] stage;
        logic [MAC_W-1:0] mac;
    } strm_t;

    strm_t            st_d, st_q;
    logic [LEN_W-1:0] head_raw;
    logic [LEN_W-1:0] head_len;
    logic [1:0]       ord_n;
    logic [1:0]       cnt_n;

    always_comb begin
        head_raw = len_i[st_q.ord[0]];
        head_len = (head_raw > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : head_raw;
    end

    always_comb begin
        st_d       = st_q;
        done_o     = '0;
        tx_valid_o = 1'b0;
        tx_last_o  = 1'b0;
        tx_data_o  = '0;
        rd_addr_o  = {st_q.slot, st_q.idx[WORD_AW+1:2]};
        case (st_q.st)
            S_IDLE: begin
                if (st_q.cnt != 2'd0) begin
                    st_d.slot = st_q.ord[0];
                    if (prog_i[st_q.ord[0]]) begin
                        st_d.st = S_PROG_LO;
                    end else if (head_len == '0) begin
                        done_o[st_q.ord[0]] = 1'b1;
                    end else begin
                        st_d.idx  = '0;
                        st_d.last = head_len - LEN_W'(1);
                        st_d.st   = S_SEND;
                    end
                end
            end
            S_SEND: begin
                tx_valid_o = 1'b1;
                tx_data_o  = rd_data_i[{st_q.idx[1:0], 3'b000} +: 8];
                tx_last_o  = (st_q.idx == st_q.last);
                if (tx_ready_i) begin
                    if (tx_last_o) begin
                        done_o[st_q.slot] = 1'b1;
                        st_d.st = S_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + LEN_W'(1);
                    end
                end
            end
            S_PROG_LO: begin
                rd_addr_o  = {st_q.slot, {WORD_AW{1'b0}}};
                st_d.stage = rd_data_i;
                st_d.st    = S_PROG_HI;
            end
            default: begin
                rd_addr_o = {st_q.slot, WORD_AW'(1)};
                st_d.mac  = {st_q.stage[7:0], st_q.stage[15:8], st_q.stage[23:16],
                             st_q.stage[31:24], rd_data_i[7:0], rd_data_i[15:8]};
                done_o[st_q.slot] = 1'b1;
                st_d.st = S_IDLE;
            end
        endcase

        ord_n = st_q.ord;
        cnt_n = st_q.cnt;
        if (|done_o) begin
            ord_n[0] = st_q.ord[1];
            cnt_n    = st_q.cnt - 2'd1;
        end
        if (|launch_i) begin
            if (cnt_n == 2'd0) begin
                ord_n[0] = launch_i[1];
            end else begin
                ord_n[1] = launch_i[1];
            end
            cnt_n = cnt_n + 2'd1;
        end
        st_d.ord = ord_n;
        st_d.cnt = cnt_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mac_o = st_q.mac;

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_last_o) && $stable(rd_addr_o)));

    assert_order_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= 2'd2);
endmodule

// File: rtl/ptx_tx_ctrl.sv
module ptx_tx_ctrl
    import ptx_pkg::*;
#(
    parameter int MAX_LEN = 1514,
    parameter int LEN_W   = 16,
    parameter int MAC_W   = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BUS_W-1:0]   host_wdata,
    output logic [BUS_W-1:0]   host_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    input  logic               tx_ready,
    output logic [MAC_W-1:0]   mac_addr,
    output logic               irq
);
    localparam int WORDS   = (MAX_LEN + 3) / 4;
    localparam int WORD_AW = $clog2(WORDS);
    localparam int OFS_WW  = SLOT_OFS_W - 2;

    typedef struct packed {
        logic gie;
    } glob_t;

    glob_t                            glob_d, glob_q;
    logic                             sel_slot;
    logic [SLOT_OFS_W-1:0]            ofs;
    logic [OFS_WW-1:0]                word_idx;
    logic                             ram_we;
    logic [WORD_AW:0]                 ram_raddr;
    logic [BUS_W-1:0]                 ram_rdata;
    logic [NUM_SLOTS-1:0]             wr_stat, wr_len, launch, done, prog, ie, pend;
    logic [NUM_SLOTS-1:0][LEN_W-1:0]  len;
    logic [NUM_SLOTS-1:0][BUS_W-1:0]  stat;

    assign sel_slot = host_addr[HOST_AW-1];
    assign ofs      = host_addr[SLOT_OFS_W-1:0];
    assign word_idx = ofs[SLOT_OFS_W-1:2];
    assign ram_we   = host_we && (word_idx < OFS_WW'(WORDS));

    ptx_frame_ram #(.WORD_AW(WORD_AW), .DATA_W(BUS_W)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .waddr_i ({sel_slot, word_idx[WORD_AW-1:0]}),
        .wdata_i (host_wdata),
        .raddr_i (ram_raddr),
        .rdata_o (ram_rdata)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign wr_stat[g] = host_we && (sel_slot == g[0]) && (ofs == OFS_STAT);
        assign wr_len[g]  = host_we && (sel_slot == g[0]) && (ofs == OFS_LEN);

        ptx_slot #(.LEN_W(LEN_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_stat_i (wr_stat[g]),
            .wr_len_i  (wr_len[g]),
            .wdata_i   (host_wdata),
            .done_i    (done[g]),
            .prog_o    (prog[g]),
            .ie_o      (ie[g]),
            .pend_o    (pend[g]),
            .len_o     (len[g]),
            .stat_o    (stat[g]),
            .launch_o  (launch[g])
        );
    end

    ptx_streamer #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .WORD_AW (WORD_AW),
        .MAC_W   (MAC_W)
    ) u_strm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .prog_i     (prog),
        .len_i      (len),
        .rd_addr_o  (ram_raddr),
        .rd_data_i  (ram_rdata),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .tx_last_o  (tx_last),
        .tx_ready_i (tx_ready),
        .done_o     (done),
        .mac_o      (mac_addr)
    );

    always_comb begin
        glob_d = glob_q;
        if (host_we && !sel_slot && (ofs == OFS_GIE)) begin
            glob_d.gie = host_wdata[GIE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q <= '0;
        end else begin
            glob_q <= glob_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (ofs == OFS_LEN) begin
            host_rdata[LEN_W-1:0] = len[sel_slot];
        end else if (ofs == OFS_STAT) begin
            host_rdata = stat[sel_slot];
        end else if ((ofs == OFS_GIE) && !sel_slot) begin
            host_rdata[GIE_BIT] = glob_q.gie;
        end
    end

    assign irq = glob_q.gie && |(ie & pend);

    assert_irq_needs_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (glob_q.gie && (pend != '0)));
endmodule

// File: tb/ptx_tx_ctrl_bench.sv
module ptx_tx_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic [47:0] mac_addr;

    always #5 clk = ~clk;

    ptx_tx_ctrl u_ptx_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .mac_addr(mac_addr), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit [7:0] mm [2][2048];
    int exp_d[$];
    int exp_l[$];
    int exp_s[$];
    bit busy_m[2], ie_m[2], sw_m[2], pend_m[2];
    bit gie_m = 1'b0;
    int len_m[2];
    bit irq_chk = 1'b0;
    bit stall_en = 1'b0;
    int cyc = 0;
    bit hold_pend = 1'b0;
    logic [7:0] hold_data;
    logic hold_last;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin : monitor
        int d, l, s;
        if (rst_n) begin
            cyc++;
            if (irq_chk)
                chk(irq === (gie_m & ((ie_m[0] & pend_m[0]) | (ie_m[1] & pend_m[1]))),
                    "R9 irq level", irq,
                    gie_m & ((ie_m[0] & pend_m[0]) | (ie_m[1] & pend_m[1])));
            if (hold_pend)
                chk(tx_valid && tx_data == hold_data && tx_last == hold_last,
                    "R4 stalled byte held", {tx_valid, tx_last, tx_data}, {1'b1, hold_last, hold_data});
            tx_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
            hold_pend = tx_valid && !tx_ready;
            hold_data = tx_data;
            hold_last = tx_last;
            if (tx_valid && tx_ready) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R5 unexpected byte", tx_data, 0);
                end else begin
                    d = exp_d.pop_front();
                    l = exp_l.pop_front();
                    s = exp_s.pop_front();
                    chk(tx_data == d[7:0] && tx_last == l[0], "R2 byte and last marker",
                        {tx_last, tx_data}, {l[0], d[7:0]});
                    if (l != 0) begin
                        busy_m[s] = 1'b0;
                        pend_m[s] = 1'b1;
                    end
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #2;
        d = host_rdata;
    endtask

    task automatic fill(input int s, input int nbytes, input int seed);
        for (int w = 0; w < (nbytes + 3) / 4; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 4; k++) begin
                word[8*k +: 8] = 8'((seed + (4*w + k) * 13) & 255);
                mm[s][4*w + k] = word[8*k +: 8];
            end
            wr(12'(s * 2048 + w * 4), word);
        end
    endtask

    task automatic set_len(input int s, input int l);
        wr(12'(s * 2048 + 'h7F4), 32'(l));
        len_m[s] = l & 'hFFFF;
    endtask

    task automatic set_stat(input int s, input logic [31:0] d);
        int n;
        wr(12'(s * 2048 + 'h7FC), d);
        pend_m[s] = 1'b0;
        ie_m[s] = d[3];
        sw_m[s] = d[31];
        if (d[0] && !d[1] && !busy_m[s]) begin
            n = (len_m[s] > 1514) ? 1514 : len_m[s];
            for (int i = 0; i < n; i++) begin
                exp_d.push_back(mm[s][i]);
                exp_l.push_back(i == n - 1 ? 1 : 0);
                exp_s.push_back(s);
            end
            if (n > 0) busy_m[s] = 1'b1;
        end
    endtask

    task automatic set_gie(input bit b);
        wr(12'h7F8, {b, 31'b0});
        gie_m = b;
    endtask

    task automatic wait_idle();
        while (exp_d.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_stat(input int s, input string req);
        logic [31:0] v, e;
        rd(12'(s * 2048 + 'h7FC), v);
        e = {sw_m[s], 27'b0, ie_m[s], 1'b0, 1'b0, busy_m[s]};
        chk(v == e, req, v, e);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin : stimulus
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(12'h7FC, v); chk(v == 0, "R10 slot0 status after reset", v, 0);
        rd(12'hFFC, v); chk(v == 0, "R10 slot1 status after reset", v, 0);
        rd(12'h7F4, v); chk(v == 0, "R10 slot0 length after reset", v, 0);
        rd(12'h7F8, v); chk(v == 0, "R10 global enable after reset", v, 0);
        chk(tx_valid == 0 && irq == 0 && mac_addr == 0, "R10 outputs after reset",
            {tx_valid, irq, mac_addr}, 0);

        // R2 R3 R9: single short frame
        set_gie(1'b1);
        fill(0, 10, 'h10);
        set_len(0, 10);
        rd(12'h7F4, v); chk(v == 10, "R1 length readback", v, 10);
        irq_chk = 1'b1;
        set_stat(0, 32'h9);
        wait_idle();
        chk_stat(0, "R3 busy cleared after frame");
        chk(irq == 1'b1, "R9 irq after completion", irq, 1);
        set_stat(0, 32'h8);
        chk(irq == 1'b0, "R9 status write clears pending", irq, 0);

        // R5 R3 R4: launch order with stalls, relaunch of busy slot ignored
        stall_en = 1'b1;
        fill(1, 23, 'h40); set_len(1, 23);
        fill(0, 17, 'h80); set_len(0, 17);
        set_stat(1, 32'h9);
        set_stat(0, 32'h9);
        chk_stat(0, "R3 busy while waiting");
        set_stat(1, 32'h9);
        rd(12'hFF4, v); chk(v == 23, "R1 slot1 length readback", v, 23);
        wait_idle();
        stall_en = 1'b0;
        chk_stat(1, "R5 slot1 done");
        set_stat(0, 32'h8);
        set_stat(1, 32'h8);

        // R8: software flag kept across a frame
        set_stat(0, 32'h8000_0009);
        wait_idle();
        chk_stat(0, "R8 software flag kept");
        set_stat(0, 32'h8000_0008);
        chk_stat(0, "R8 software flag readback");

        // R6: clamp to 1514
        fill(0, 1516, 'h21);
        set_len(0, 1600);
        rd(12'h7F4, v); chk(v == 1600, "R1 long length readback", v, 1600);
        set_stat(0, 32'h9);
        wait_idle();
        chk_stat(0, "R6 clamped frame done");
        set_stat(0, 32'h8);

        // R6: empty frame
        irq_chk = 1'b0;
        set_len(1, 0);
        set_stat(1, 32'h9);
        repeat (5) @(negedge clk);
        chk_stat(1, "R6 empty frame clears busy");
        chk(irq == 1'b1, "R6 empty frame completion pending", irq, 1);
        set_stat(1, 32'h8);
        irq_chk = 1'b1;

        // R9: global and per-slot masking
        set_gie(1'b0);
        fill(1, 5, 'h77); set_len(1, 5);
        set_stat(1, 32'h9);
        wait_idle();
        chk(irq == 1'b0, "R9 global enable masks", irq, 0);
        set_gie(1'b1);
        chk(irq == 1'b1, "R9 pending shows after enable", irq, 1);
        set_stat(1, 32'h1);
        wait_idle();
        chk(irq == 1'b0, "R9 slot enable masks", irq, 0);
        set_stat(1, 32'h8);

        // R7: station address load
        irq_chk = 1'b0;
        wr(12'h800, 32'h4433_2211);
        wr(12'h804, 32'h0000_6655);
        set_len(1, 6);
        wr(12'hFFC, 32'h3);
        repeat (6) @(negedge clk);
        rd(12'hFFC, v); chk(v == 0, "R7 bits cleared after load", v, 0);
        chk(mac_addr == 48'h1122_3344_5566, "R7 station address", mac_addr, 48'h1122_3344_5566);
        wr(12'hFFC, 32'h2);
        repeat (4) @(negedge clk);
        rd(12'hFFC, v); chk(v == 0, "R7 lone bit1 ignored", v, 0);
        chk(mac_addr == 48'h1122_3344_5566, "R7 address unchanged", mac_addr, 48'h1122_3344_5566);
        ie_m[1] = 1'b0; pend_m[1] = 1'b0; sw_m[1] = 1'b0;
        irq_chk = 1'b1;

        // R1: map corners
        rd(12'h7F8, v); chk(v == 32'h8000_0000, "R1 global enable readback", v, 32'h8000_0000);
        rd(12'hFF8, v); chk(v == 0, "R1 slot1 0x7F8 reads zero", v, 0);
        rd(12'h7F0, v); chk(v == 0, "R1 unmapped offset reads zero", v, 0);

        wait_idle();
        finish_run();
    end
endmodule